// File: doc/BRIEF.md
# Descriptor-Chained DMA Engine

This block moves data between on-card memory and host memory under control of a small 32-bit register interface. Software loads the host address of a descriptor list into a pointer register, enables a direction, and writes a command code. The engine then fetches descriptors from host memory and copies the data one 32-bit word at a time. Each transfer reads a word from the source memory port and writes it to the destination port.

Two directions exist. The card-to-host direction (called "write") follows a chain of up to eight descriptors. The host-to-card direction (called "read") uses exactly one descriptor. Each descriptor is three consecutive host words. The words are ordered by direction, and a flag in the length word ends a chain. When a transfer finishes, the engine raises a one-cycle done pulse. A malformed list sets sticky error bits and raises a one-cycle error pulse. A cancel or stop command ends a transfer cleanly at a word boundary.

Both memory sides are plain request/acknowledge word ports. A request and its address, write flag and write data stay asserted until the matching acknowledge. Read data is valid in the acknowledge cycle.

Top module: `dma_sg_engine`

## Requirements
- R1: After reset, the status register reads 0, no memory request is asserted, and all done and error pulses are low.
- R2: Register offsets are as follows. Offset 0x00 is the command register and reads as 0. Offset 0x04 is status, offset 0x08 is the read-list pointer, offset 0x0C is the write-list pointer, and offset 0x10 is the enable register (bit0 enables reads, bit1 enables writes). The pointers and the enable register read back what was written.
- R3: Command 1 starts a read and command 2 starts a write. The engine fetches each descriptor as three host reads at the list pointer, the pointer plus 4 and the pointer plus 8. A write descriptor is ordered card address, host address, length. A read descriptor is ordered host address, card address, length. The next write descriptor follows 12 bytes later.
- R4: Each data word is read from the source port and then written to the destination port. Both addresses advance by 4 per word. A length of L bytes (bits 30:0) moves ceil(L/4) words.
- R5: Bit 31 of a write descriptor's length word marks the last descriptor. A read uses its single descriptor as the last one.
- R6: When the last descriptor completes, the busy bit for that direction (status bit0 read, bit1 write) clears. In the same cycle a one-cycle done pulse rises for that direction.
- R7: A descriptor length of zero aborts the transfer without moving data for that descriptor. It sets status bit4 (list error) and the direction's error bit (bit2 read, bit3 write). It also clears busy and raises a one-cycle error pulse.
- R8: If the eighth descriptor of a write chain lacks the last flag, it is rejected with the same error reporting as R7. The first seven descriptors are transferred in full.
- R9: A start command for a direction whose enable bit is 0 has no effect. Command values other than 0, 1, 2 and 4 also have no effect.
- R10: A start command issued while either direction is busy is ignored.
- R11: Command 0 (cancel) or 4 (stop) issued while busy ends the transfer after the current word's destination write. It clears busy and raises neither a done nor an error pulse.
- R12: At most one memory port is requested at a time. A request holds its address until acknowledged.
- R13: A start in a direction clears that direction's error bit and the list error bit. The other direction's error bit is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| host_req | output | 1 | Host port request |
| host_we | output | 1 | Host port write flag |
| host_addr | output | 32 | Host port byte address |
| host_wdata | output | 32 | Host port write data |
| host_ack | input | 1 | Host port acknowledge |
| host_rdata | input | 32 | Host port read data |
| card_req | output | 1 | Card port request |
| card_we | output | 1 | Card port write flag |
| card_addr | output | 32 | Card port byte address |
| card_wdata | output | 32 | Card port write data |
| card_ack | input | 1 | Card port acknowledge |
| card_rdata | input | 32 | Card port read data |
| rd_done | output | 1 | Read direction completion pulse |
| wr_done | output | 1 | Write direction completion pulse |
| rd_err | output | 1 | Read direction error pulse |
| wr_err | output | 1 | Write direction error pulse |

## Verification
The assertions check, on every cycle, the properties that hold at any instant:
- only one memory port is requested at a time, and a pending request keeps its address;
- the two directions are never busy together;
- done pulses last one cycle and coincide with busy being clear;
- a list error is always accompanied by a direction error;
- a start clears that direction's error bit.

Only the bench scenarios can show the rest. These are the exact order and addresses of descriptor fetches and data words, the rounding of odd lengths, where a chain stops on its last flag or at the eighth entry, that ignored commands leave the ports quiet, and that cancel and stop cut a transfer only after whole words.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {WK_IDLE, WK_FETCH, WK_SRC, WK_DST} wk_state_e;

  localparam logic [7:0] RA_CMD  = 8'h00;
  localparam logic [7:0] RA_STAT = 8'h04;
  localparam logic [7:0] RA_RPTR = 8'h08;
  localparam logic [7:0] RA_WPTR = 8'h0C;
  localparam logic [7:0] RA_ENA  = 8'h10;

  localparam logic [31:0] CMD_CANCEL = 32'd0;
  localparam logic [31:0] CMD_READ   = 32'd1;
  localparam logic [31:0] CMD_WRITE  = 32'd2;
  localparam logic [31:0] CMD_STOP   = 32'd4;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [7:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          busy_rd,
  input  logic          busy_wr,
  input  logic          err_rd,
  input  logic          err_wr,
  output logic [DW-1:0] rd_ptr,
  output logic [DW-1:0] wr_ptr,
  output logic          start_rd,
  output logic          start_wr,
  output logic          abort_cmd
);
  logic [DW-1:0] rptr_q, rptr_d, wptr_q, wptr_d;
  logic [1:0]    ena_q, ena_d;
  logic          rerr_q, rerr_d, werr_q, werr_d, lerr_q, lerr_d;
  logic          cmd_wr;

  assign cmd_wr    = reg_we && (reg_addr == RA_CMD);
  assign start_rd  = cmd_wr && (reg_wdata == CMD_READ)  && ena_q[0] && !busy_rd && !busy_wr;
  assign start_wr  = cmd_wr && (reg_wdata == CMD_WRITE) && ena_q[1] && !busy_rd && !busy_wr;
  assign abort_cmd = cmd_wr && ((reg_wdata == CMD_CANCEL) || (reg_wdata == CMD_STOP));
  assign rd_ptr    = rptr_q;
  assign wr_ptr    = wptr_q;

  always_comb begin
    rptr_d = rptr_q;
    wptr_d = wptr_q;
    ena_d  = ena_q;
    rerr_d = rerr_q;
    werr_d = werr_q;
    lerr_d = lerr_q;
    if (reg_we && (reg_addr == RA_RPTR)) rptr_d = reg_wdata;
    if (reg_we && (reg_addr == RA_WPTR)) wptr_d = reg_wdata;
    if (reg_we && (reg_addr == RA_ENA))  ena_d  = reg_wdata[1:0];
    if (start_rd) rerr_d = 1'b0;
    if (start_wr) werr_d = 1'b0;
    if (start_rd || start_wr) lerr_d = 1'b0;
    if (err_rd) rerr_d = 1'b1;
    if (err_wr) werr_d = 1'b1;
    if (err_rd || err_wr) lerr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      wptr_q <= '0;
      ena_q  <= '0;
      rerr_q <= 1'b0;
      werr_q <= 1'b0;
      lerr_q <= 1'b0;
    end else begin
      rptr_q <= rptr_d;
      wptr_q <= wptr_d;
      ena_q  <= ena_d;
      rerr_q <= rerr_d;
      werr_q <= werr_d;
      lerr_q <= lerr_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_STAT: reg_rdata[4:0] = {lerr_q, werr_q, rerr_q, busy_wr, busy_rd};
      RA_RPTR: reg_rdata      = rptr_q;
      RA_WPTR: reg_rdata      = wptr_q;
      RA_ENA:  reg_rdata[1:0] = ena_q;
      default: reg_rdata      = '0;
    endcase
  end

  // R7
  ll_has_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lerr_q |-> (rerr_q || werr_q));

  // R13
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> !werr_q && !lerr_q);
endmodule

// File: rtl/dma_walker.sv
module dma_walker
  import dma_pkg::*;
#(
  parameter int DW       = 32,
  parameter int MAX_DESC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_rd,
  input  logic          start_wr,
  input  logic          abort_cmd,
  input  logic [DW-1:0] rd_ptr,
  input  logic [DW-1:0] wr_ptr,
  output logic          host_req,
  output logic          host_we,
  output logic [DW-1:0] host_addr,
  output logic [DW-1:0] host_wdata,
  input  logic          host_ack,
  input  logic [DW-1:0] host_rdata,
  output logic          card_req,
  output logic          card_we,
  output logic [DW-1:0] card_addr,
  output logic [DW-1:0] card_wdata,
  input  logic          card_ack,
  input  logic [DW-1:0] card_rdata,
  output logic          busy_rd,
  output logic          busy_wr,
  output logic          done_rd,
  output logic          done_wr,
  output logic          err_rd,
  output logic          err_wr
);
  localparam int CW = $clog2(MAX_DESC) + 1;
  localparam int LW = DW - 2;

  wk_state_e     st_q, st_d;
  logic          dir_q, dir_d;
  logic [DW-1:0] lptr_q, lptr_d, ca_q, ca_d, ha_q, ha_d, data_q, data_d;
  logic [1:0]    fidx_q, fidx_d;
  logic [CW-1:0] dcnt_q, dcnt_d;
  logic [LW-1:0] left_q, left_d;
  logic          last_q, last_d, abt_q, abt_d;
  logic          dnr_d, dnw_d, erw_d, err_d;
  logic          abort_now, src_ack, dst_ack, len_zero, chain_over;
  logic [DW-1:0] len_up, src_rdata;

  assign abort_now  = abt_q || abort_cmd;
  assign src_ack    = dir_q ? card_ack : host_ack;
  assign dst_ack    = dir_q ? host_ack : card_ack;
  assign src_rdata  = dir_q ? card_rdata : host_rdata;
  assign len_up     = {1'b0, host_rdata[DW-2:0]} + DW'(3);
  assign len_zero   = (host_rdata[DW-2:0] == '0);
  assign chain_over = dir_q && !host_rdata[DW-1] && (dcnt_q == CW'(MAX_DESC - 1));

  always_comb begin
    st_d = st_q;   dir_d = dir_q;   lptr_d = lptr_q; ca_d = ca_q;
    ha_d = ha_q;   data_d = data_q; fidx_d = fidx_q; dcnt_d = dcnt_q;
    left_d = left_q; last_d = last_q; abt_d = abt_q;
    dnr_d = 1'b0; dnw_d = 1'b0; err_d = 1'b0; erw_d = 1'b0;
    if (abort_cmd && (st_q != WK_IDLE)) abt_d = 1'b1;
    case (st_q)
      WK_IDLE: if (start_rd || start_wr) begin
        st_d   = WK_FETCH;
        dir_d  = start_wr;
        lptr_d = start_wr ? wr_ptr : rd_ptr;
        fidx_d = 2'd0;
        dcnt_d = '0;
      end
      WK_FETCH: if (host_ack) begin
        fidx_d = fidx_q + 2'd1;
        if (fidx_q == 2'd0) begin
          if (dir_q) ca_d = host_rdata; else ha_d = host_rdata;
        end else if (fidx_q == 2'd1) begin
          if (dir_q) ha_d = host_rdata; else ca_d = host_rdata;
        end else begin
          fidx_d = 2'd0;
          lptr_d = lptr_q + DW'(12);
          dcnt_d = dcnt_q + CW'(1);
          last_d = !dir_q || host_rdata[DW-1];
          left_d = len_up[DW-1:2];
        end
        if (abort_now) st_d = WK_IDLE;
        else if (fidx_q == 2'd2) begin
          if (len_zero || chain_over) begin
            st_d  = WK_IDLE;
            erw_d = dir_q;
            err_d = !dir_q;
          end else st_d = WK_SRC;
        end
      end
      WK_SRC: if (src_ack) begin
        data_d = src_rdata;
        st_d   = WK_DST;
      end
      WK_DST: if (dst_ack) begin
        ca_d   = ca_q + DW'(4);
        ha_d   = ha_q + DW'(4);
        left_d = left_q - LW'(1);
        if (abort_now) st_d = WK_IDLE;
        else if (left_q == LW'(1)) begin
          if (last_q) begin
            st_d  = WK_IDLE;
            dnw_d = dir_q;
            dnr_d = !dir_q;
          end else st_d = WK_FETCH;
        end else st_d = WK_SRC;
      end
      default: st_d = WK_IDLE;
    endcase
    if (st_d == WK_IDLE) abt_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= WK_IDLE; dir_q <= 1'b0; lptr_q <= '0; ca_q <= '0; ha_q <= '0;
      data_q <= '0; fidx_q <= '0; dcnt_q <= '0; left_q <= '0; last_q <= 1'b0;
      abt_q <= 1'b0; done_rd <= 1'b0; done_wr <= 1'b0; err_rd <= 1'b0; err_wr <= 1'b0;
    end else begin
      st_q <= st_d; dir_q <= dir_d; lptr_q <= lptr_d; ca_q <= ca_d; ha_q <= ha_d;
      data_q <= data_d; fidx_q <= fidx_d; dcnt_q <= dcnt_d; left_q <= left_d;
      last_q <= last_d; abt_q <= abt_d; done_rd <= dnr_d; done_wr <= dnw_d;
      err_rd <= err_d; err_wr <= erw_d;
    end
  end

  assign busy_rd    = (st_q != WK_IDLE) && !dir_q;
  assign busy_wr    = (st_q != WK_IDLE) && dir_q;
  assign host_req   = (st_q == WK_FETCH) || ((st_q == WK_SRC) && !dir_q) || ((st_q == WK_DST) && dir_q);
  assign card_req   = ((st_q == WK_SRC) && dir_q) || ((st_q == WK_DST) && !dir_q);
  assign host_we    = (st_q == WK_DST);
  assign card_we    = (st_q == WK_DST);
  assign host_addr  = (st_q == WK_FETCH) ? (lptr_q + {{(DW-4){1'b0}}, fidx_q, 2'b00}) : ha_q;
  assign card_addr  = ca_q;
  assign host_wdata = data_q;
  assign card_wdata = data_q;

  // R12
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_req && card_req));

  // R12
  hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_ack) |=> (host_req && $stable(host_addr)));

  // R10
  one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_rd && busy_wr));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_rd || done_wr) |=> !(done_rd || done_wr));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_rd || done_wr) |-> !(busy_rd || busy_wr));
endmodule

// File: rtl/dma_sg_engine.sv
module dma_sg_engine
  import dma_pkg::*;
#(
  parameter int DW       = 32,
  parameter int MAX_DESC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [7:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          host_req,
  output logic          host_we,
  output logic [DW-1:0] host_addr,
  output logic [DW-1:0] host_wdata,
  input  logic          host_ack,
  input  logic [DW-1:0] host_rdata,
  output logic          card_req,
  output logic          card_we,
  output logic [DW-1:0] card_addr,
  output logic [DW-1:0] card_wdata,
  input  logic          card_ack,
  input  logic [DW-1:0] card_rdata,
  output logic          rd_done,
  output logic          wr_done,
  output logic          rd_err,
  output logic          wr_err
);
  logic          busy_rd, busy_wr, start_rd, start_wr, abort_cmd;
  logic [DW-1:0] rd_ptr, wr_ptr;

  dma_regs #(.DW(DW)) i_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy_rd(busy_rd),
    .busy_wr(busy_wr), .err_rd(rd_err), .err_wr(wr_err), .rd_ptr(rd_ptr),
    .wr_ptr(wr_ptr), .start_rd(start_rd), .start_wr(start_wr), .abort_cmd(abort_cmd)
  );

  dma_walker #(.DW(DW), .MAX_DESC(MAX_DESC)) i_walker (
    .clk(clk), .rst_n(rst_n), .start_rd(start_rd), .start_wr(start_wr),
    .abort_cmd(abort_cmd), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
    .card_req(card_req), .card_we(card_we), .card_addr(card_addr),
    .card_wdata(card_wdata), .card_ack(card_ack), .card_rdata(card_rdata),
    .busy_rd(busy_rd), .busy_wr(busy_wr), .done_rd(rd_done), .done_wr(wr_done),
    .err_rd(rd_err), .err_wr(wr_err)
  );
endmodule

// File: tb/test_dma_sg_engine.sv
module test_dma_sg_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        host_req, host_we, card_req, card_we;
  logic [31:0] host_addr, host_wdata, card_addr, card_wdata;
  logic        host_ack = 1'b0, card_ack = 1'b0;
  logic [31:0] host_rdata = '0, card_rdata = '0;
  logic        rd_done, wr_done, rd_err, wr_err;

  int tests = 0, fails = 0;
  int n_rdone = 0, n_wdone = 0, n_rerr = 0, n_werr = 0, n_req = 0;
  logic [31:0] hm [0:255];
  logic [31:0] cm [0:255];
  int          q_port[$], q_we[$];
  logic [31:0] q_addr[$], q_data[$];

  always #5 clk = ~clk;

  dma_sg_engine i_dma_sg_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_req(host_req),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_ack(host_ack), .host_rdata(host_rdata), .card_req(card_req),
    .card_we(card_we), .card_addr(card_addr), .card_wdata(card_wdata),
    .card_ack(card_ack), .card_rdata(card_rdata), .rd_done(rd_done),
    .wr_done(wr_done), .rd_err(rd_err), .wr_err(wr_err)
  );

  // memory responders: acknowledge one cycle after a request
  always @(posedge clk) begin
    host_ack <= host_req && !host_ack;
    if (host_req && !host_ack) begin
      host_rdata <= hm[host_addr[9:2]];
      if (host_we) hm[host_addr[9:2]] <= host_wdata;
    end
    card_ack <= card_req && !card_ack;
    if (card_req && !card_ack) begin
      card_rdata <= cm[card_addr[9:2]];
      if (card_we) cm[card_addr[9:2]] <= card_wdata;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle comparison of the memory access stream against the model
  always @(negedge clk) begin
    if (rst_n) begin
      n_rdone += rd_done; n_wdone += wr_done; n_rerr += rd_err; n_werr += wr_err;
      if (host_req || card_req) n_req++;
      if (host_ack || card_ack) begin
        if (q_port.size() == 0) begin
          tests++; fails++;
          $display("FAIL R3 R4: actual unexpected access at %h expected none",
                   card_ack ? card_addr : host_addr);
        end else begin
          int p, w; logic [31:0] a, d;
          p = q_port.pop_front(); w = q_we.pop_front();
          a = q_addr.pop_front(); d = q_data.pop_front();
          check("R3 R4 port", {31'd0, card_ack}, p[31:0]);
          check("R3 R4 we", {31'd0, card_ack ? card_we : host_we}, w[31:0]);
          check("R3 R4 addr", card_ack ? card_addr : host_addr, a);
          if (w == 1) check("R4 data", card_ack ? card_wdata : host_wdata, d);
        end
      end
    end
  end

  task automatic push(input int port, input int we, input logic [31:0] a, input logic [31:0] d);
    q_port.push_back(port); q_we.push_back(we); q_addr.push_back(a); q_data.push_back(d);
  endtask

  task automatic model_run(input bit wr, input int ptr, output int dn, output int er);
    int p = ptr, n = 0;
    bit fin = 0;
    dn = 0; er = 0;
    while (!fin) begin
      logic [31:0] w0, w1, w2, ca, ha;
      int len, words;
      w0 = hm[p / 4]; w1 = hm[p / 4 + 1]; w2 = hm[p / 4 + 2];
      push(0, 0, p, 0); push(0, 0, p + 4, 0); push(0, 0, p + 8, 0);
      ca = wr ? w0 : w1; ha = wr ? w1 : w0;
      len = int'(w2[30:0]);
      if (len == 0 || (wr && !w2[31] && n == 7)) begin
        er = 1; fin = 1;
      end else begin
        words = (len + 3) / 4;
        for (int k = 0; k < words; k++) begin
          if (wr) begin
            push(1, 0, ca + 4 * k, 0);
            push(0, 1, ha + 4 * k, cm[(ca + 4 * k) / 4]);
          end else begin
            push(0, 0, ha + 4 * k, 0);
            push(1, 1, ca + 4 * k, hm[(ha + 4 * k) / 4]);
          end
        end
        n++; p += 12;
        if (!wr || w2[31]) begin dn = 1; fin = 1; end
      end
    end
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      reg_read(8'h04, s);
      if (s[1:0] == 2'b00) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_counts();
    n_rdone = 0; n_wdone = 0; n_rerr = 0; n_werr = 0; n_req = 0;
  endtask

  task automatic put_desc(input int at, input logic [31:0] a, input logic [31:0] b, input logic [31:0] l);
    hm[at / 4] = a; hm[at / 4 + 1] = b; hm[at / 4 + 2] = l;
  endtask

  task automatic run(input bit wr, input int ptr, input logic [31:0] exp_st, input string req);
    int dn, er;
    logic [31:0] s;
    clear_counts();
    model_run(wr, ptr, dn, er);
    reg_write(wr ? 8'h0C : 8'h08, ptr);
    reg_write(8'h00, wr ? 32'd2 : 32'd1);
    wait_idle();
    reg_read(8'h04, s);
    check({req, " status"}, s, exp_st);
    check({req, " done pulses"}, wr ? n_wdone : n_rdone, dn);
    check({req, " error pulses"}, wr ? n_werr : n_rerr, er);
    check({req, " stream drained"}, q_port.size(), 0);
  endtask

  task automatic abort_run(input bit wr, input int ptr, input logic [31:0] code, input logic [31:0] exp_st);
    int dn, er;
    logic [31:0] s;
    clear_counts();
    model_run(wr, ptr, dn, er);
    reg_write(wr ? 8'h0C : 8'h08, ptr);
    reg_write(8'h00, wr ? 32'd2 : 32'd1);
    repeat (20) @(negedge clk);
    reg_write(8'h00, code);
    wait_idle();
    reg_read(8'h04, s);
    check("R11 status after abort", s, exp_st);
    check("R11 no done pulse", n_rdone + n_wdone, 0);
    check("R11 no error pulse", n_rerr + n_werr, 0);
    check("R11 transfer cut short", {31'd0, q_port.size() > 0}, 1);
    check("R11 whole words only", q_port.size() % 2, 0);
    q_port.delete(); q_we.delete(); q_addr.delete(); q_data.delete();
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] s;
    for (int i = 0; i < 256; i++) begin
      hm[i] = 32'hA500_0000 + i;
      cm[i] = 32'hC000_0000 + i;
    end
    // write chain: 8 bytes, 5 bytes (rounds to 2 words), 4 bytes last
    put_desc(32'h00, 32'h000, 32'h200, 32'd8);
    put_desc(32'h0C, 32'h010, 32'h220, 32'd5);
    put_desc(32'h18, 32'h020, 32'h240, 32'h8000_0004);
    for (int k = 0; k < 8; k++)
      put_desc(32'h40 + 12 * k, 32'h040 + 4 * k, 32'h280 + 4 * k, 32'd4);
    put_desc(32'hA0, 32'h060, 32'h2C0, 32'd8);
    put_desc(32'hAC, 32'h070, 32'h2E0, 32'h8000_0000);
    put_desc(32'hC0, 32'h300, 32'h280, 32'd0);
    put_desc(32'hD0, 32'h300, 32'h200, 32'd12);
    put_desc(32'hE0, 32'h300, 32'h300, 32'd64);
    put_desc(32'hF0, 32'h080, 32'h380, 32'h8000_0040);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    reg_read(8'h04, s);
    check("R1 status", s, 32'h0);
    check("R1 requests", {31'd0, host_req | card_req}, 0);
    check("R1 pulses", {28'd0, rd_done, wr_done, rd_err, wr_err}, 0);

    // R2 register readback
    reg_write(8'h08, 32'h1234_5670);
    reg_write(8'h0C, 32'h0BAD_F00C);
    reg_write(8'h10, 32'h3);
    reg_read(8'h08, s); check("R2 read pointer", s, 32'h1234_5670);
    reg_read(8'h0C, s); check("R2 write pointer", s, 32'h0BAD_F00C);
    reg_read(8'h10, s); check("R2 enable", s, 32'h3);
    reg_read(8'h00, s); check("R2 command reads zero", s, 32'h0);

    // R7 read with zero length: list error + read error
    run(1'b0, 32'hC0, 32'h14, "R7 read zero length");

    // R9 disabled direction and unknown code
    reg_write(8'h10, 32'h0);
    clear_counts();
    reg_write(8'h0C, 32'h00);
    reg_write(8'h00, 32'd2);
    reg_write(8'h10, 32'h3);
    reg_write(8'h00, 32'd3);
    repeat (10) @(negedge clk);
    check("R9 no requests", n_req, 0);
    reg_read(8'h04, s); check("R9 status unchanged", s, 32'h14);

    // R3 R4 R5 R6 write chain with an ignored read start mid-run (R10, R13)
    begin
      int dn, er;
      clear_counts();
      model_run(1'b1, 32'h00, dn, er);
      reg_write(8'h00, 32'd2);
      repeat (4) @(negedge clk);
      reg_write(8'h00, 32'd1);
      reg_read(8'h04, s);
      check("R10 read not started while busy", {31'd0, s[0]}, 0);
      check("R13 write start clears list error", {31'd0, s[4]}, 0);
      wait_idle();
      reg_read(8'h04, s);
      check("R13 read error kept", s, 32'h04);
      check("R6 write done pulse", n_wdone, 1);
      check("R10 no read done", n_rdone, 0);
      check("R5 stream drained", q_port.size(), 0);
      check("R4 host word", hm[32'h224 / 4], 32'hC000_0005);
      check("R4 host last word", hm[32'h240 / 4], 32'hC000_0008);
    end

    // R5 R6 single read descriptor
    run(1'b0, 32'hD0, 32'h00, "R6 read transfer");
    check("R4 card word", cm[32'h208 / 4], 32'hA500_00C2);

    // R7 zero length mid-chain
    run(1'b1, 32'hA0, 32'h18, "R7 write zero length");
    // R8 eight descriptors without last flag
    run(1'b1, 32'h40, 32'h18, "R8 chain overrun");
    check("R8 seventh moved", hm[32'h298 / 4], 32'hC000_0016);
    check("R8 eighth not moved", hm[32'h29C / 4], 32'hA500_00A7);

    // R11 cancel during read, stop during write
    abort_run(1'b0, 32'hE0, 32'd0, 32'h08);
    abort_run(1'b1, 32'hF0, 32'd4, 32'h00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule